// File: doc/BRIEF.md
# Serial-Link Frame Type Selector

This block is the word-level framing stage of a serial link transmitter. It runs once per frame clock. In each cycle it picks one of three frame kinds: a data frame carrying a user word, a control frame carrying a control word, or a fill frame that keeps the far-end receiver locked when there is nothing to send. It then builds the frame from a 4-bit coding field, one flag bit and a 16-bit payload. If sending the frame unchanged would push the accumulated line balance further from zero, it sends the frame complemented and raises an inversion indicator.

The flag bit works in one of two ways. It can carry one extra transparent user bit in data frames. It can also toggle by itself on each data frame, so that the receiver can check for strict alternation. There are two fill types. When the second type is selected, the block chooses between its two variants from the sign of the running disparity, so that the fill frames themselves pull the line back toward balance.

The frame, its kind tag and the inversion indicator come out of registers, one cycle after the inputs are sampled.

Top module: `frame_type_sel`

## Requirements
- R1: While the asynchronous active-low reset is asserted, `frame_o` is all zeros, `kind_o` is 0 (fill) and `inv_o` is 0. Reset also clears the running disparity and the flag toggle state to zero.
- R2: Payload frames are allowed only after the enable has been seen low and then high since reset. The enable counts as high during reset, so an enable held high through reset does not allow payload. A fill frame is sent whenever payload is not allowed, whenever `en_i` is low, and whenever neither valid strobe is high.
- R3: When payload is allowed and both `cvalid_i` and `dvalid_i` are high, a control frame (`kind_o` = 2) is sent. With only `dvalid_i` high, a data frame (`kind_o` = 1) is sent.
- R4: The frame before any inversion is {code[20:17], flag[16], payload[15:0]}. The codes are: data 4'b1100, control 4'b0110, type-0 fill 4'b1010, type-1 fill for non-positive disparity 4'b1110, and type-1 fill for positive disparity 4'b0001. A data payload is `dword_i`, a control payload is `cword_i`, and a fill payload is 16'hAAAA with flag 0.
- R5: A fill frame sent with `fill_sel_i` low uses the type-0 fill code.
- R6: A fill frame sent with `fill_sel_i` high uses code 4'b1110 when the running disparity is zero or negative, and code 4'b0001 when it is positive.
- R7: In a data frame with `flag_mode_i` high, the flag bit equals `flag_i`.
- R8: In a data frame with `flag_mode_i` low, `flag_i` is ignored. The flag bit is then the toggle state, which starts at 0 and flips after every data frame, in either flag mode. Control and fill frames leave the toggle state unchanged.
- R9: A control frame always has flag bit 0, whatever `flag_i` and `flag_mode_i` are.
- R10: Disparity means ones minus zeros over the 21 frame bits. A frame is sent complemented, with `inv_o` high, exactly when its own disparity is non-zero and has the same sign as a non-zero running total. The running total then adds the disparity of the frame as sent, so a non-zero total always moves toward zero.
- R11: The outputs change only at a rising clock edge. They reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Payload enable |
| dvalid_i | input | 1 | Data word valid |
| cvalid_i | input | 1 | Control word valid |
| dword_i | input | 16 | Data word |
| cword_i | input | 16 | Control word |
| fill_sel_i | input | 1 | Fill type select (0: type-0, 1: type-1) |
| flag_mode_i | input | 1 | 1: flag is a user bit, 0: flag toggles by itself |
| flag_i | input | 1 | Extra user flag bit |
| frame_o | output | 21 | Frame as sent |
| kind_o | output | 2 | Frame kind: 0 fill, 1 data, 2 control |
| inv_o | output | 1 | High when the frame is sent complemented |

## Verification
The assertions assume that every input has a known value at each rising edge. They also assume the frame width is odd, which with the default parameters means no frame has zero disparity. The strict move toward zero in the running total depends on this. The flag-alternation assertion assumes that the flag mode seen at an edge is the one that applies to the frame coming out of that edge. The bench meets these conditions by changing inputs only one time unit after a rising edge, by keeping the default widths, and by always driving every input to 0 or 1, including while reset is held.

// File: rtl/frm_pkg.sv
package frm_pkg;

  typedef enum logic [1:0] {
    KIND_FILL = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CTRL = 2'd2
  } frame_kind_e;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_DATA   = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_CTRL   = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_FILL0  = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_FILL1P = 4'b1110;  // used at disparity <= 0
  localparam logic [CODE_W-1:0] CODE_FILL1N = 4'b0001;  // used at disparity > 0

endpackage

// File: rtl/frm_kind_sel.sv
module frm_kind_sel
  import frm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        dvalid_i,
  input  logic        cvalid_i,
  output frame_kind_e kind_o,
  output logic        pay_ok_o
);

  logic en_q, en_d;
  logic armed_q, armed_d;

  // R2: arming needs a low-to-high enable seen after reset; en_q resets high
  always_comb begin
    en_d     = en_i;
    armed_d  = armed_q | (en_i & ~en_q);
    pay_ok_o = en_i & (armed_q | ~en_q);
  end

  // R3: control beats data
  always_comb begin
    if (pay_ok_o && cvalid_i) begin
      kind_o = KIND_CTRL;
    end else if (pay_ok_o && dvalid_i) begin
      kind_o = KIND_DATA;
    end else begin
      kind_o = KIND_FILL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/frm_flag_gen.sv
module frm_flag_gen
  import frm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  frame_kind_e kind_i,
  input  logic        flag_mode_i,
  input  logic        flag_i,
  output logic        flag_o
);

  logic tog_q, tog_d;
  logic adv;

  always_comb begin
    adv   = (kind_i == KIND_DATA);
    tog_d = ~tog_q;
    if (kind_i == KIND_DATA) begin
      flag_o = flag_mode_i ? flag_i : tog_q;
    end else begin
      flag_o = 1'b0;  // R9: control and fill frames never carry the user bit
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
    end else if (adv) begin
      tog_q <= tog_d;
    end
  end

endmodule

// File: rtl/frm_balance.sv
module frm_balance #(
  parameter int FRAME_W = 21,
  parameter int RD_W    = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [FRAME_W-1:0]     raw_i,
  output logic [FRAME_W-1:0]     sent_o,
  output logic                   flip_o,
  output logic signed [RD_W-1:0] rd_o
);

  localparam int ONES_W = $clog2(FRAME_W + 1);

  logic [ONES_W-1:0]     ones;
  logic signed [RD_W-1:0] disp_raw;
  logic signed [RD_W-1:0] disp_sent;
  logic signed [RD_W-1:0] rd_q, rd_d;

  always_comb begin
    ones      = ONES_W'($countones(raw_i));
    disp_raw  = RD_W'(2 * int'(ones) - FRAME_W);
    flip_o    = (rd_q != '0) && (disp_raw != '0) &&
                (disp_raw[RD_W-1] == rd_q[RD_W-1]);
    disp_sent = flip_o ? -disp_raw : disp_raw;
    sent_o    = flip_o ? ~raw_i : raw_i;
    rd_d      = rd_q + disp_sent;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_o = rd_q;

endmodule

// File: rtl/frame_type_sel.sv
module frame_type_sel
  import frm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                dvalid_i,
  input  logic                cvalid_i,
  input  logic [DATA_W-1:0]   dword_i,
  input  logic [DATA_W-1:0]   cword_i,
  input  logic                fill_sel_i,
  input  logic                flag_mode_i,
  input  logic                flag_i,
  output logic [CODE_W+DATA_W:0] frame_o,
  output logic [1:0]          kind_o,
  output logic                inv_o
);

  localparam int FRAME_W  = CODE_W + 1 + DATA_W;
  localparam int RD_W     = $clog2(FRAME_W + 1) + 2;
  localparam logic [DATA_W-1:0] FILL_PAY = DATA_W'({(DATA_W/2){2'b10}});

  frame_kind_e            kind_c;
  logic                   pay_ok;
  logic                   flag_bit;
  logic [CODE_W-1:0]      code_c;
  logic [DATA_W-1:0]      pay_c;
  logic [FRAME_W-1:0]     raw_c;
  logic [FRAME_W-1:0]     sent_c;
  logic                   flip_c;
  logic signed [RD_W-1:0] rd_cur;

  logic [FRAME_W-1:0] frame_q;
  frame_kind_e        kind_q;
  logic               inv_q;

  frm_kind_sel u_kind (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .dvalid_i (dvalid_i),
    .cvalid_i (cvalid_i),
    .kind_o   (kind_c),
    .pay_ok_o (pay_ok)
  );

  frm_flag_gen u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kind_i      (kind_c),
    .flag_mode_i (flag_mode_i),
    .flag_i      (flag_i),
    .flag_o      (flag_bit)
  );

  // R4..R6: code and payload per kind
  always_comb begin
    unique case (kind_c)
      KIND_DATA: begin
        code_c = CODE_DATA;
        pay_c  = dword_i;
      end
      KIND_CTRL: begin
        code_c = CODE_CTRL;
        pay_c  = cword_i;
      end
      default: begin
        pay_c = FILL_PAY;
        if (!fill_sel_i) begin
          code_c = CODE_FILL0;
        end else if (rd_cur > 0) begin
          code_c = CODE_FILL1N;
        end else begin
          code_c = CODE_FILL1P;
        end
      end
    endcase
    raw_c = {code_c, flag_bit, pay_c};
  end

  frm_balance #(
    .FRAME_W (FRAME_W),
    .RD_W    (RD_W)
  ) u_bal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_c),
    .sent_o (sent_c),
    .flip_o (flip_c),
    .rd_o   (rd_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      kind_q  <= KIND_FILL;
      inv_q   <= 1'b0;
    end else begin
      frame_q <= sent_c;
      kind_q  <= kind_c;
      inv_q   <= flip_c;
    end
  end

  assign frame_o = frame_q;
  assign kind_o  = kind_q;
  assign inv_o   = inv_q;

endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
  parameter int DATA_W = 16,
  parameter int RD_W   = 7
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   en_i,
  input logic                   dvalid_i,
  input logic                   cvalid_i,
  input logic                   flag_mode_i,
  input logic                   pay_ok,
  input logic [DATA_W+4:0]      frame_o,
  input logic [1:0]             kind_o,
  input logic                   inv_o,
  input logic signed [RD_W-1:0] rd
);

  localparam int FRAME_W  = DATA_W + 5;
  localparam int FLAG_POS = DATA_W;

  logic past_ok;
  logic dcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      dcnt    <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (kind_o == 2'd1) begin
        dcnt <= ~dcnt;
      end
    end
  end

  assert_fill_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!en_i || (!dvalid_i && !cvalid_i)) |-> kind_o == 2'd0);

  assert_ctrl_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(pay_ok && cvalid_i) |-> kind_o == 2'd2);

  assert_kind_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o != 2'd3);

  assert_flag_alternates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && kind_o == 2'd1 && !$past(flag_mode_i) |->
      (frame_o[FLAG_POS] ^ inv_o) == dcnt);

  assert_ctrl_flag_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == 2'd2 |-> (frame_o[FLAG_POS] ^ inv_o) == 1'b0);

  assert_rd_falls_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(rd) > 0 |-> rd < $past(rd));

  assert_rd_rises_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(rd) < 0 |-> rd > $past(rd));

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      assert_rd_bound_R10: assert (int'(rd) <= FRAME_W && int'(rd) >= -FRAME_W);
    end
  end

endmodule

bind frame_type_sel frm_checker #(
  .DATA_W (DATA_W),
  .RD_W   (RD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .dvalid_i    (dvalid_i),
  .cvalid_i    (cvalid_i),
  .flag_mode_i (flag_mode_i),
  .pay_ok      (pay_ok),
  .frame_o     (frame_o),
  .kind_o      (kind_o),
  .inv_o       (inv_o),
  .rd          (rd_cur)
);

// File: tb/test_frame_type_sel.sv
module test_frame_type_sel;

  typedef struct packed {
    logic        en;
    logic        dav;
    logic        cav;
    logic        fsel;
    logic        fmode;
    logic        flag;
    logic [15:0] dw;
    logic [15:0] cw;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h1234,16'h0000,2'd0}, // R2 enable low
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,16'h1234,16'h0000,2'd1}, // R8 flag 0
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h5678,16'h0000,2'd1}, // R8 flag 1
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'hC3C3,2'd2}, // R9
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,16'h9999,16'h0F00,2'd2}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,2'd0}, // R5
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,2'd0}, // R6
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'hFFFF,16'h0000,2'd1}, // R7
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,16'hFFFF,16'h0000,2'd1}, // R7
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,2'd0}, // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,2'd1}, // R8
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'hFFFF,2'd2}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,2'd0}, // R6
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,2'd1}, // R10
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,2'd0}, // R5
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0F0F,16'h0000,2'd1}  // R4
  };

  logic        clk;
  logic        rst_n;
  logic        en, dav, cav, fsel, fmode, flag;
  logic [15:0] dw, cw;
  logic [20:0] frame;
  logic [1:0]  kind;
  logic        inv;

  int n_cmp;
  int n_bad;

  // bench-side reference state, derived from the requirements
  int m_rd;
  bit m_tog;
  bit m_enq;
  bit m_armed;

  frame_type_sel i_frame_type_sel (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .dvalid_i    (dav),
    .cvalid_i    (cav),
    .dword_i     (dw),
    .cword_i     (cw),
    .fill_sel_i  (fsel),
    .flag_mode_i (fmode),
    .flag_i      (flag),
    .frame_o     (frame),
    .kind_o      (kind),
    .inv_o       (inv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rd = 0; m_tog = 1'b0; m_enq = 1'b1; m_armed = 1'b0;
  endtask

  task automatic model(input vec_t v, output logic [20:0] sent, output logic s_inv,
                       output logic [1:0] s_kind, output logic [20:0] raw);
    bit go;
    int d;
    bit fl;
    go     = v.en && (m_armed || !m_enq);
    m_armed = m_armed || (v.en && !m_enq);
    m_enq  = v.en;
    s_kind = (go && v.cav) ? 2'd2 : (go && v.dav) ? 2'd1 : 2'd0;
    fl = 1'b0;
    if (s_kind == 2'd1) begin
      fl = v.fmode ? v.flag : m_tog;
      m_tog = ~m_tog;
    end
    case (s_kind)
      2'd1:    raw = {4'b1100, fl, v.dw};
      2'd2:    raw = {4'b0110, 1'b0, v.cw};
      default: raw = {(!v.fsel) ? 4'b1010 : (m_rd > 0) ? 4'b0001 : 4'b1110, 1'b0, 16'hAAAA};
    endcase
    d = 2 * $countones(raw) - 21;
    s_inv = (m_rd != 0) && (d != 0) && ((d > 0) == (m_rd > 0));
    sent  = s_inv ? ~raw : raw;
    m_rd  = m_rd + (s_inv ? -d : d);
  endtask

  task automatic step(input vec_t v, input bit use_tbl);
    logic [20:0] e_frame, e_raw;
    logic        e_inv;
    logic [1:0]  e_kind;
    en = v.en; dav = v.dav; cav = v.cav; fsel = v.fsel;
    fmode = v.fmode; flag = v.flag; dw = v.dw; cw = v.cw;
    model(v, e_frame, e_inv, e_kind, e_raw);
    @(posedge clk);
    #1;
    chk(use_tbl ? "R3 kind (table)" : "R2 kind", 32'(kind), 32'(use_tbl ? v.kind : e_kind));
    chk("R4 frame", 32'(frame), 32'(e_frame));
    chk("R10 inversion", 32'(inv), 32'(e_inv));
    if (e_kind == 2'd1) begin
      chk(v.fmode ? "R7 flag" : "R8 flag", 32'(frame[16] ^ inv), 32'(e_raw[16]));
    end else if (e_kind == 2'd2) begin
      chk("R9 flag", 32'(frame[16] ^ inv), 32'(1'b0));
    end else begin
      chk(v.fsel ? "R6 fill code" : "R5 fill code", 32'(frame[20:17] ^ {4{inv}}),
          32'(e_raw[20:17]));
    end
  endtask

  function automatic vec_t mk(input logic e, input logic d, input logic c,
                              input logic fm, input logic f, input logic [15:0] w);
    vec_t v;
    v = '{e, d, c, 1'b0, fm, f, w, 16'h0000, 2'd0};
    return v;
  endfunction

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL R11 watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [20:0] hold;
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0;
    en = 1'b0; dav = 1'b0; cav = 1'b0; fsel = 1'b0;
    fmode = 1'b0; flag = 1'b0; dw = '0; cw = '0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset frame", 32'(frame), 32'h0);
    chk("R1 reset kind", 32'(kind), 32'h0);
    chk("R1 reset inv", 32'(inv), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i], 1'b1);
    end

    // R11: new inputs do not reach the outputs before the edge
    hold = frame;
    en = 1'b1; dav = 1'b1; cav = 1'b0; dw = 16'h3C3C;
    #5;
    chk("R11 before edge", 32'(frame), 32'(hold));
    step(mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h3C3C), 1'b0);

    // R1 and R2: asynchronous reset with the enable held high
    en = 1'b1; dav = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1 async frame", 32'(frame), 32'h0);
    chk("R1 async kind", 32'(kind), 32'h0);
    chk("R1 async inv", 32'(inv), 32'h0);
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h7777), 1'b0);  // R2 still fill
    step(mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h7777), 1'b0);  // R2 still fill
    step(mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h7777), 1'b0);  // R2 low
    step(mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h7777), 1'b0);  // R8 flag from 0
    step(mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000), 1'b0);  // R8 no advance
    step(mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF), 1'b0);  // R8 flag 1
    step(mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF), 1'b0);  // R10
    step(mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000), 1'b0);  // R10

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule